// File: doc/BRIEF.md
# Capability Revocation Bit Lookup

This block answers one question per request: has the capability stored at a given address been revoked? Revocation state is kept as a bitmap in ordinary memory. Each 8-byte capability granule above a configurable heap base has one bit in that bitmap. The block takes a lookup request that carries a 32-bit address. It clears the granule offset bits and works out which bitmap byte and which bit inside that byte belong to the granule. It then fetches that byte with a single read on a simple request/response memory port.

When the read data comes back, the selected bit is presented as the revoked flag, together with a one-cycle done strobe. Addresses below the heap base are never revoked and cost no memory traffic. The heap base and the bitmap base are configuration inputs that are sampled when a request is accepted. Typical settings are 0x8000_0000 for the heap and 0x8300_0000 for the bitmap.

The block serves one lookup at a time. It drops its ready output from the cycle after acceptance until the result has been delivered. The memory response may arrive any number of cycles after the read request is taken.

Top module: `cap_revoke_probe`

## Requirements
- R1: The low three bits of the lookup address have no effect: addresses that differ only in bits [2:0] give the same memory read address and the same result.
- R2: If the address with bits [2:0] cleared is below `heap_base`, the block raises `done` with `revoked` = 0 and never asserts `mem_req_valid` for that lookup. An aligned address equal to `heap_base` is not below it.
- R3: Otherwise the single byte read is issued at `map_base + ((aligned - heap_base) >> 6)`, where aligned is the lookup address with bits [2:0] cleared.
- R4: The result is bit `((aligned - heap_base) >> 3) & 7` of the returned byte, where bit 0 is the least significant bit of `mem_rsp_data`.
- R5: `req_ready` is 1 in idle and 0 from the cycle after a request is accepted until the cycle after `done`. A `req_valid` raised during that time is ignored and does not alter the result.
- R6: `done` is high for exactly one cycle per accepted lookup. `revoked` keeps its value from the `done` cycle until the next request is accepted.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. The block then waits any number of cycles for `mem_rsp_valid` and takes the data only in that cycle.
- R8: After reset, `req_ready` = 1 and `done`, `revoked` and `mem_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| heap_base | input | 32 | Lowest address covered by the bitmap |
| map_base | input | 32 | Byte address of the first bitmap byte |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Address of the capability to test |
| mem_req_valid | output | 1 | Bitmap byte read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion strobe |
| revoked | output | 1 | Lookup result |

## Verification
The main sweep walks 256 consecutive granules above the heap base and gives each one a different pattern in its low three bits. This exercises every bit position across 32 bitmap bytes and separates correct granule-to-bit indexing from off-by-one or wrong-shift mappings. The bitmap contents come from an address-dependent byte pattern and from all-ones and all-zeros fills. These separate a correctly selected bit from a constant result or from a neighbouring bit. Grant delay and response latency both vary across lookups, which shows that the block waits for the handshakes rather than counting cycles. Further lookups test just below, exactly at and far below the heap base, repeat the sweep with a small second pair of bases, and drive spurious requests while the block is busy.

// File: rtl/revoke_pkg.sv
package revoke_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } probe_state_e;
endpackage

// File: rtl/revoke_index.sv
// Maps a lookup address to the bitmap word address and bit lane.
module revoke_index #(
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LG2 = 3,
   parameter int DATA_W    = 8
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [ADDR_W-1:0]          heap_base,
   input  logic [ADDR_W-1:0]          map_base,
   output logic                       below,
   output logic [ADDR_W-1:0]          word_addr,
   output logic [$clog2(DATA_W)-1:0]  bit_sel
);
   localparam int SEL_W      = $clog2(DATA_W);
   localparam int WORD_SHIFT = GRAIN_LG2 + SEL_W;
   localparam int LANE_LG2   = $clog2(DATA_W / 8);

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] offset;

   generate
      if (GRAIN_LG2 == 0) begin : g_no_align
         assign aligned = addr;
      end else begin : g_align
         localparam logic [ADDR_W-1:0] GRAIN_MASK = {{(ADDR_W-GRAIN_LG2){1'b1}}, {GRAIN_LG2{1'b0}}};
         assign aligned = addr & GRAIN_MASK;
      end
   endgenerate

   always_comb begin
      below     = (aligned < heap_base);
      offset    = aligned - heap_base;
      word_addr = map_base + ((offset >> WORD_SHIFT) << LANE_LG2);
      bit_sel   = offset[GRAIN_LG2 +: SEL_W];
   end
endmodule

// File: rtl/revoke_ctrl.sv
// One-at-a-time lookup sequencer: accept, read, wait, report.
module revoke_ctrl
   import revoke_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       below,
   input  logic [ADDR_W-1:0]          word_addr,
   input  logic [$clog2(DATA_W)-1:0]  bit_sel,
   output logic                       mem_req_valid,
   input  logic                       mem_req_ready,
   output logic [ADDR_W-1:0]          mem_req_addr,
   input  logic                       mem_rsp_valid,
   input  logic [DATA_W-1:0]          mem_rsp_data,
   output logic                       done,
   output logic                       revoked
);
   localparam int SEL_W = $clog2(DATA_W);

   probe_state_e        state_q, state_d;
   logic [ADDR_W-1:0]   addr_q;
   logic [SEL_W-1:0]    sel_q;
   logic                result_q;
   logic                accept;

   assign accept = req_valid && (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_valid)     state_d = below ? ST_DONE : ST_READ;
         ST_READ: if (mem_req_ready) state_d = ST_WAIT;
         ST_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
         ST_DONE:                    state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         sel_q    <= '0;
         result_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q   <= word_addr;
            sel_q    <= bit_sel;
            result_q <= 1'b0;
         end else if ((state_q == ST_WAIT) && mem_rsp_valid) begin
            result_q <= mem_rsp_data[sel_q];
         end
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_READ);
   assign mem_req_addr  = addr_q;
   assign done          = (state_q == ST_DONE);
   assign revoked       = result_q;
endmodule

// File: rtl/cap_revoke_probe.sv
module cap_revoke_probe #(
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LG2 = 3,
   parameter int DATA_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  heap_base,
   input  logic [ADDR_W-1:0]  map_base,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [DATA_W-1:0]  mem_rsp_data,
   output logic               done,
   output logic               revoked
);
   localparam int SEL_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("DATA_W must be a power of two of at least 8");
      end
      if (GRAIN_LG2 + SEL_W >= ADDR_W) begin : g_bad_grain
         $error("GRAIN_LG2 too large for ADDR_W");
      end
   endgenerate

   logic              below;
   logic [ADDR_W-1:0] word_addr;
   logic [SEL_W-1:0]  bit_sel;

   revoke_index #(
      .ADDR_W    (ADDR_W),
      .GRAIN_LG2 (GRAIN_LG2),
      .DATA_W    (DATA_W)
   ) u_index (
      .addr      (req_addr),
      .heap_base (heap_base),
      .map_base  (map_base),
      .below     (below),
      .word_addr (word_addr),
      .bit_sel   (bit_sel)
   );

   revoke_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .below         (below),
      .word_addr     (word_addr),
      .bit_sel       (bit_sel),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .revoked       (revoked)
   );
endmodule

// File: rtl/cap_revoke_probe_chk.sv
module cap_revoke_probe_chk #(
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LG2 = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  heap_base,
   input logic               req_valid,
   input logic               req_ready,
   input logic [ADDR_W-1:0]  req_addr,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic [ADDR_W-1:0]  mem_req_addr,
   input logic               done,
   input logic               revoked
);
   localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'((1 << GRAIN_LG2) - 1));

   logic low_hit;
   assign low_hit = req_valid && req_ready && ((req_addr & KEEP) < heap_base);

   AST_BELOW_SKIPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      low_hit |=> (done && !mem_req_valid && !revoked)); // R2

   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !(req_valid && req_ready)) |=> (done || $stable(revoked))); // R6

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || done) |-> !req_ready); // R5

   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R5
endmodule

bind cap_revoke_probe cap_revoke_probe_chk #(
   .ADDR_W    (ADDR_W),
   .GRAIN_LG2 (GRAIN_LG2)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .heap_base     (heap_base),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .revoked       (revoked)
);

// File: tb/sim_cap_revoke_probe.sv
`timescale 1ns/1ps
module sim_cap_revoke_probe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] heap_base = 32'h8000_0000;
   logic [31:0] map_base  = 32'h8300_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [7:0]  mem_rsp_data = '0;
   logic        done;
   logic        revoked;

   int checks = 0;
   int failures = 0;
   int fill_mode = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cap_revoke_probe u0 (.*);

   function automatic logic [7:0] memf(input logic [31:0] a);
      if (fill_mode == 1) return 8'hFF;
      if (fill_mode == 2) return 8'h00;
      return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] a, input int rdly, input int lat, input bit poke);
      logic [31:0] al, off, ea, maddr;
      logic        exp_below, exp_rv, rv, saw_mem, got, busy_ready, multi_addr;
      int          bitn, wcnt, lcnt;
      bit          granted, responded;
      al = a & ~32'h7;
      exp_below = al < heap_base;
      off = al - heap_base;
      ea = map_base + (off >> 6);
      bitn = int'((off >> 3) & 32'h7);
      exp_rv = exp_below ? 1'b0 : memf(ea)[bitn];
      saw_mem = 0; got = 0; rv = 0; maddr = '0; busy_ready = 0; multi_addr = 0;
      granted = 0; responded = 0; wcnt = 0; lcnt = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      for (int c = 0; c < 60 && !got; c++) begin
         @(negedge clk);
         req_valid = poke; req_addr = a ^ 32'h0000_0140;
         mem_rsp_valid = 1'b0;
         if (done) begin
            got = 1; rv = revoked; req_valid = 1'b0; mem_req_ready = 1'b0;
         end else begin
            if (req_ready) busy_ready = 1;
            if (mem_req_valid && !granted) begin
               if (saw_mem && mem_req_addr != maddr) multi_addr = 1;
               saw_mem = 1; maddr = mem_req_addr;
               if (wcnt == rdly) begin mem_req_ready = 1'b1; granted = 1; end
               else begin mem_req_ready = 1'b0; wcnt++; end
            end else begin
               mem_req_ready = 1'b0;
               if (granted && !responded) begin
                  if (lcnt == lat) begin
                     mem_rsp_valid = 1'b1; mem_rsp_data = memf(maddr); responded = 1;
                  end else lcnt++;
               end
            end
         end
      end
      req_valid = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
      chk(got, "R6 done seen", {31'b0, got}, 32'd1);
      chk(!busy_ready, "R5 ready low while busy", {31'b0, busy_ready}, 32'd0);
      chk(saw_mem == !exp_below, "R2 memory read issued only at or above heap base", {31'b0, saw_mem}, {31'b0, !exp_below});
      if (!exp_below) begin
         chk(maddr == ea, "R3 bitmap byte address", maddr, ea);
         chk(!multi_addr, "R7 read address stable until granted", {31'b0, multi_addr}, 32'd0);
      end
      chk(rv == exp_rv, exp_below ? "R2 below base not revoked" : "R4 selected bit", {31'b0, rv}, {31'b0, exp_rv});
      @(negedge clk);
      chk(!done, "R6 done single cycle", {31'b0, done}, 32'd0);
      repeat (2) @(negedge clk);
      chk(revoked == rv, "R6 result held", {31'b0, revoked}, {31'b0, rv});
      chk(req_ready, "R5 ready back in idle", {31'b0, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R8 reset ready", {31'b0, req_ready}, 32'd1);
      chk(done == 1'b0, "R8 reset done", {31'b0, done}, 32'd0);
      chk(revoked == 1'b0, "R8 reset revoked", {31'b0, revoked}, 32'd0);
      chk(mem_req_valid == 1'b0, "R8 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
      rst_n = 1'b1;
      // R1 R3 R4 R7: granule sweep with varied low bits, grant delay and latency
      for (int g = 0; g < 256; g++)
         lookup(32'h8000_0000 + 32'(g * 8) + 32'(g % 8), g % 3, (g / 3) % 4, (g % 5) == 0);
      // R1: low bits give identical result
      for (int lo = 0; lo < 8; lo++) lookup(32'h8000_0A48 + 32'(lo), 1, 2, 0);
      // R4: constant fills tell selected bit from constant output
      for (int m = 1; m <= 2; m++) begin
         fill_mode = m;
         for (int g = 0; g < 16; g++) lookup(32'h8000_1000 + 32'(g * 8), 0, g % 3, 0);
      end
      fill_mode = 0;
      // R2: boundary around the heap base
      lookup(32'h7FFF_FFF8, 0, 0, 0);
      lookup(32'h7FFF_FFFF, 0, 0, 1);
      lookup(32'h0000_0000, 0, 0, 0);
      lookup(32'h8000_0007, 2, 3, 0);
      // second base pair, small sweep
      heap_base = 32'h0000_1000; map_base = 32'h0000_0040;
      for (int g = 0; g < 72; g++)
         lookup(32'h0000_0FC0 + 32'(g * 8) + 32'(7 - (g % 8)), g % 2, g % 5, (g % 7) == 3);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule